// File: doc/BRIEF.md
# Decimating Pixel Capture Writer

This block captures one image from a clocked image sensor and stores a reduced copy of it in an external SRAM of 1024 six-bit words. When `start` is pulsed, it runs the sensor clock and waits for the sensor to raise `sensor_read`. It then gives one priming clock pulse and reads the pixel stream. Of every four pixel clocks in a row it keeps the first. After each kept row it clocks out three whole rows and throws them away. With the default parameters this turns a 128-clock-wide stream into a 32x32 picture.

The sensor clock is generated internally. It is high for one system clock and low for the next. A pixel is taken from the upper six bits of the converter input at the end of the high phase of its clock. The SRAM write for that pixel happens during the three clocks that are skipped after it. The write address starts at 0 and increases by one per pixel. When the last word has been written, `done` pulses for one cycle and the sensor clock stays low.

States: `CAP_IDLE` (waits for `start`), `CAP_HUNT` (toggles the clock until `sensor_read` is seen in a high phase), `CAP_PRIME` (low, high, low: the priming pulse), `CAP_ROW` (groups of eight system cycles, one kept pixel each), `CAP_SKIP` (discards three rows), `CAP_FINISH` (the `done` cycle).

Transitions:
- IDLE to HUNT on `start`.
- HUNT to PRIME on `sensor_read` in a high phase.
- PRIME to ROW after three cycles.
- ROW to SKIP after the last group of a row.
- ROW to FINISH after the last word of the frame.
- SKIP to ROW after 768 cycles.
- FINISH to IDLE.

Top module: `subsample_capture`

## Requirements
- R1: After reset, and whenever idle, `sens_clk`=0, `sram_we_n`=1, `sram_oe_n`=0, `sram_dq_en`=0 and `done`=0.
- R2: `sensor_read` has no effect while idle. After `start`, `sens_clk` alternates low and high, one system cycle each, until `sensor_read` is 1 at the end of a high cycle.
- R3: After `sensor_read` is seen, exactly one priming rising edge of `sens_clk` occurs before the first kept pixel.
- R4: Within a row, of every four rising edges of `sens_clk` only the first is sampled. There are 32 kept pixels per 128-edge row.
- R5: After each kept row except the last, 384 more rising edges occur with no SRAM write. A frame has 16001 rising edges after `sensor_read` is seen.
- R6: The stored word is bits [7:2] of `pix_in`, sampled at the end of the high cycle of the kept edge, and is driven on `sram_dq[5:0]` bit for bit.
- R7: Each frame makes exactly 1024 writes, to addresses 0, 1, 2, ... 1023 in order. Kept pixel (row r, column c) goes to address 32*r + c.
- R8: In each write, `sram_oe_n` goes high first, then `sram_dq_en` goes high, then `sram_we_n` is low for exactly one cycle, then `sram_oe_n` is released. Address and data are stable while `sram_we_n` is low and in the cycle after.
- R9: `done` is a one-cycle pulse after the last write. `sens_clk` stays low from then on until the next `start`.
- R10: `sram_dq_en` is 1 only while `sram_oe_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low synchronous reset |
| start | input | 1 | begins a capture when idle |
| sensor_read | input | 1 | sensor signals that pixel data follows |
| pix_in | input | 8 | converted pixel value |
| sens_clk | output | 1 | generated sensor clock |
| sram_addr | output | 10 | SRAM word address |
| sram_dq | output | 6 | SRAM write data |
| sram_dq_en | output | 1 | tri-state enable for `sram_dq` |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| done | output | 1 | one-cycle pulse when the frame is stored |

## Verification
The assertions assume that `start` is only pulsed while the block is idle. They also assume that `pix_in` changes only in response to rising edges of `sens_clk`, and that `sensor_read` stays put through the high cycle in which it is sampled. The bench's sensor model honours all of these. It updates `pix_in` half a system cycle after each observed rising edge, raises `sensor_read` during a high phase after a chosen number of hunting edges, and keeps it high until the frame ends. Each frame uses a different pixel pattern, so that a skipped or shifted sample shows up as a wrong stored word.

// File: rtl/capt_pkg.sv
package capt_pkg;
    typedef enum logic [2:0] {
        CAP_IDLE,
        CAP_HUNT,
        CAP_PRIME,
        CAP_ROW,
        CAP_SKIP,
        CAP_FINISH
    } cap_state_e;
endpackage

// File: rtl/capt_pixel_latch.sv
module capt_pixel_latch #(
    parameter int ADC_W = 8,
    parameter int PIX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [ADC_W-1:0] adc,
    output logic [PIX_W-1:0] pix
);
    localparam int SH = ADC_W - PIX_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix <= '0;
        end else if (take) begin
            pix <= PIX_W'(adc >> SH);
        end
    end
endmodule

// File: rtl/capt_sram_strobe.sv
module capt_sram_strobe #(
    parameter int K_W = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_row,
    input  logic [K_W-1:0] k,
    output logic           oe_n,
    output logic           dq_en,
    output logic           we_n
);
    localparam logic [K_W-1:0] SLOT_OE  = K_W'(3);
    localparam logic [K_W-1:0] SLOT_DQ  = K_W'(4);
    localparam logic [K_W-1:0] SLOT_WE  = K_W'(5);
    localparam logic [K_W-1:0] SLOT_END = K_W'(6);

    always_comb begin
        oe_n  = 1'b0;
        dq_en = 1'b0;
        we_n  = 1'b1;
        if (in_row) begin
            oe_n  = (k >= SLOT_OE) && (k <= SLOT_END);
            dq_en = (k >= SLOT_DQ) && (k <= SLOT_END);
            we_n  = (k != SLOT_WE);
        end
    end

    // R8
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> we_n);

    // R10
    dq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_en |-> oe_n);

    // R8
    oe_before_dq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_en) |-> $past(oe_n));
endmodule

// File: rtl/subsample_capture.sv
module subsample_capture
    import capt_pkg::*;
#(
    parameter  int ROW_CLKS = 128,
    parameter  int DEC      = 4,
    parameter  int OUT_ROWS = 32,
    parameter  int ADC_W    = 8,
    parameter  int PIX_W    = 6,
    localparam int OUT_COLS = ROW_CLKS / DEC,
    localparam int FRAME    = OUT_COLS * OUT_ROWS,
    localparam int AW       = $clog2(FRAME)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             sensor_read,
    input  logic [ADC_W-1:0] pix_in,
    output logic             sens_clk,
    output logic [AW-1:0]    sram_addr,
    output logic [PIX_W-1:0] sram_dq,
    output logic             sram_dq_en,
    output logic             sram_we_n,
    output logic             sram_oe_n,
    output logic             done
);
    localparam int K_W      = $clog2(2 * DEC);
    localparam int GRP_W    = (OUT_COLS > 1) ? $clog2(OUT_COLS) : 1;
    localparam int SKIP_CYC = 2 * (DEC - 1) * ROW_CLKS;
    localparam int SK_W     = $clog2(SKIP_CYC);

    localparam logic [K_W-1:0]   K_LAST     = K_W'(2 * DEC - 1);
    localparam logic [K_W-1:0]   K_PRIME_HI = K_W'(1);
    localparam logic [K_W-1:0]   K_PRIME_END = K_W'(2);
    localparam logic [GRP_W-1:0] GRP_LAST   = GRP_W'(OUT_COLS - 1);
    localparam logic [SK_W-1:0]  SKIP_LAST  = SK_W'(SKIP_CYC - 1);
    localparam logic [AW-1:0]    ADDR_LAST  = AW'(FRAME - 1);

    cap_state_e state, nxt;
    logic [K_W-1:0]   k;
    logic [GRP_W-1:0] grp;
    logic [SK_W-1:0]  skc;
    logic [AW-1:0]    addr;
    logic             take;
    logic [PIX_W-1:0] pix;
    logic             group_end;

    assign group_end = (state == CAP_ROW) && (k == K_LAST);

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            CAP_IDLE:   if (start) nxt = CAP_HUNT;
            CAP_HUNT:   if (k[0] && sensor_read) nxt = CAP_PRIME;
            CAP_PRIME:  if (k == K_PRIME_END) nxt = CAP_ROW;
            CAP_ROW: begin
                if (k == K_LAST) begin
                    if (addr == ADDR_LAST)  nxt = CAP_FINISH;
                    else if (grp == GRP_LAST) nxt = CAP_SKIP;
                end
            end
            CAP_SKIP:   if (skc == SKIP_LAST) nxt = CAP_ROW;
            CAP_FINISH: nxt = CAP_IDLE;
            default:    nxt = CAP_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CAP_IDLE;
        else        state <= nxt;
    end

    // phase, group, skip and address counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k    <= '0;
            grp  <= '0;
            skc  <= '0;
            addr <= '0;
        end else begin
            if (nxt != state)          k <= '0;
            else if (state == CAP_ROW) k <= (k == K_LAST) ? '0 : k + 1'b1;
            else if ((state == CAP_HUNT) || (state == CAP_PRIME)) k <= k + 1'b1;

            if (state == CAP_SKIP) skc <= skc + 1'b1;
            else                   skc <= '0;

            if (state == CAP_IDLE) begin
                grp  <= '0;
                addr <= '0;
            end else if (group_end) begin
                grp  <= (grp == GRP_LAST) ? '0 : grp + 1'b1;
                addr <= addr + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        sens_clk = 1'b0;
        unique case (state)
            CAP_HUNT:  sens_clk = k[0];
            CAP_PRIME: sens_clk = (k == K_PRIME_HI);
            CAP_ROW:   sens_clk = ~k[0];
            CAP_SKIP:  sens_clk = ~skc[0];
            default:   sens_clk = 1'b0;
        endcase
        done = (state == CAP_FINISH);
        take = (state == CAP_ROW) && (k == '0);
    end

    capt_pixel_latch #(.ADC_W(ADC_W), .PIX_W(PIX_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .adc   (pix_in),
        .pix   (pix)
    );

    capt_sram_strobe #(.K_W(K_W)) u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_row (state == CAP_ROW),
        .k      (k),
        .oe_n   (sram_oe_n),
        .dq_en  (sram_dq_en),
        .we_n   (sram_we_n)
    );

    assign sram_addr = addr;
    assign sram_dq   = sram_dq_en ? pix : '0;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_IDLE) |-> (!sens_clk && sram_we_n && !sram_dq_en && !done));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!sens_clk && sram_addr == '0));

    // R5
    skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_SKIP) |-> (sram_we_n && !sram_dq_en));

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |=> $stable(sram_addr));

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_dq_en && $past(sram_dq_en)) |-> $stable(sram_dq));

    // R4
    write_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> !sens_clk);
endmodule

// File: tb/tb_subsample_capture.sv
module tb_subsample_capture;
    localparam int CLK_PERIOD = 10;
    localparam int ROW_CLKS = 128;
    localparam int DEC = 4;
    localparam int OUT_ROWS = 32;
    localparam int OUT_COLS = ROW_CLKS / DEC;
    localparam int FRAME = OUT_COLS * OUT_ROWS;
    localparam int LAST_EDGE = (OUT_ROWS - 1) * ROW_CLKS * DEC + ROW_CLKS;
    localparam int NVEC = 3;
    // hunting edges before sensor_read, pixel multiplier, pixel offset
    localparam int VEC [NVEC][3] = '{'{3, 37, 11}, '{9, 101, 200}, '{1, 13, 7}};

    logic clk = 0, rst_n = 0, start = 0, sensor_read = 0;
    logic [7:0] pix_in = 0;
    logic sens_clk, sram_dq_en, sram_we_n, sram_oe_n, done;
    logic [9:0] sram_addr;
    logic [5:0] sram_dq;

    subsample_capture dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sensor_read(sensor_read),
        .pix_in(pix_in), .sens_clk(sens_clk), .sram_addr(sram_addr),
        .sram_dq(sram_dq), .sram_dq_en(sram_dq_en), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .done(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int total = 0, fails = 0;
    int hunt_edges, e_idx, e_at_done, cur_h, cur_m, cur_a;
    int wr_count, order_err, proto_err, done_count, post_rises, we_run;
    bit read_seen, prev_sck;
    logic [5:0] img [FRAME];

    function automatic logic [7:0] pixf(int e, int m, int a);
        return 8'((e * m + a) & 255);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_model(int h, int m, int a);
        cur_h = h; cur_m = m; cur_a = a;
        hunt_edges = 0; e_idx = -1; e_at_done = -1;
        wr_count = 0; order_err = 0; proto_err = 0;
        done_count = 0; post_rises = 0; we_run = 0;
        read_seen = 0;
        for (int i = 0; i < FRAME; i++) img[i] = '0;
    endtask

    task automatic sensor_model();
        forever begin
            @(negedge clk);
            if (sens_clk && !prev_sck) begin
                if (done_count > 0) post_rises++;
                else if (!read_seen) begin
                    hunt_edges++;
                    if (hunt_edges == cur_h && cur_h > 0) begin
                        sensor_read = 1;
                        read_seen = 1;
                    end
                end else begin
                    e_idx++;
                    pix_in = pixf(e_idx, cur_m, cur_a);
                end
            end
            prev_sck = sens_clk;
            if (!sram_we_n) begin
                if (!(sram_oe_n && sram_dq_en)) proto_err++;
                we_run++;
                if (we_run > 1) proto_err++;
                if (int'(sram_addr) != wr_count) order_err++;
                img[sram_addr] = sram_dq;
                wr_count++;
            end else we_run = 0;
            if (sram_dq_en && !sram_oe_n) proto_err++;
            if (done) begin
                done_count++;
                e_at_done = e_idx;
                sensor_read = 0;
            end
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++; total++;
        $display("FAIL R9 watchdog: actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        clear_model(0, 1, 0);
        prev_sck = 0;
        fork sensor_model(); join_none
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!sens_clk && sram_we_n && !sram_oe_n && !sram_dq_en && !done,
            "R1", "outputs in reset", {sens_clk, sram_we_n, sram_oe_n, sram_dq_en, done}, 5'b01000);
        rst_n = 1;

        // table walk: one full frame per vector
        for (int v = 0; v < NVEC; v++) begin
            int mism, first_a, first_act, first_exp, waited;
            clear_model(VEC[v][0], VEC[v][1], VEC[v][2]);
            pulse_start();
            waited = 0;
            while (done_count == 0 && waited < 40000) begin
                @(negedge clk); waited++;
            end
            repeat (20) @(negedge clk);
            chk(done_count == 1, "R9", "done pulses", done_count, 1);
            chk(post_rises == 0 && !sens_clk, "R9", "clock edges after done", post_rises, 0);
            chk(hunt_edges == cur_h, "R2", "hunting edges", hunt_edges, cur_h);
            chk(e_at_done == LAST_EDGE, "R5", "last edge index (R3 prime included)", e_at_done, LAST_EDGE);
            chk(wr_count == FRAME, "R7", "write count", wr_count, FRAME);
            chk(order_err == 0, "R7", "out-of-order addresses", order_err, 0);
            chk(proto_err == 0, "R8", "write strobe violations (R10)", proto_err, 0);
            mism = 0; first_a = 0; first_act = 0; first_exp = 0;
            for (int a = 0; a < FRAME; a++) begin
                int e;
                logic [7:0] p;
                e = 1 + (a / OUT_COLS) * ROW_CLKS * DEC + (a % OUT_COLS) * DEC;
                p = pixf(e, cur_m, cur_a);
                if (img[a] !== p[7:2]) begin
                    if (mism == 0) begin first_a = a; first_act = img[a]; first_exp = p[7:2]; end
                    mism++;
                end
            end
            chk(mism == 0, "R4", "stored pixel (R6) mismatches", mism, 0);
            if (mism != 0)
                $display("FAIL R6 word %0d: actual=%0d expected=%0d", first_a, first_act, first_exp);
        end

        // R2: sensor_read while idle has no effect
        clear_model(1, 1, 0);
        sensor_read = 1;
        repeat (50) @(negedge clk);
        chk(hunt_edges == 0 && wr_count == 0 && !sens_clk, "R2", "idle clock edges with read high",
            hunt_edges, 0);
        sensor_read = 0;

        // R1: reset in mid-frame returns to the idle outputs
        clear_model(2, 5, 3);
        pulse_start();
        repeat (3000) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk(!sens_clk && sram_we_n && !sram_oe_n && !sram_dq_en && !done,
            "R1", "outputs after mid-frame reset", {sens_clk, sram_we_n, sram_oe_n, sram_dq_en, done}, 5'b01000);
        sensor_read = 0;
        @(negedge clk); rst_n = 1;
        clear_model(0, 1, 0);
        repeat (20) @(negedge clk);
        chk(hunt_edges == 0 && !sens_clk, "R1", "clock edges after reset release", hunt_edges, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule